// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block keeps the DRAM attached to a memory controller's chip selects alive. A programmable interval timer counts down. When it runs out it raises a refresh request. The sequencer then runs one refresh.

- Chip selects configured as fast-page or EDO DRAM get a CAS-before-RAS cycle. Its length comes from a two-bit cycle-length field.
- Chip selects configured as SDRAM get a single-clock REFRESH command, followed by a fixed recovery wait.
- When both kinds are present, the CAS-before-RAS cycle runs first and the SDRAM command follows in the next clock.

The block watches the normal access path. A request that arrives during an access to a DRAM chip select waits until that access ends. An access to a non-DRAM chip select does not hold the request back, so the refresh runs in the background. While any refresh is running, `rfsh_busy` is high, so that the access arbiter can hold off new DRAM accesses.

The sequencer states and transitions are:

- IDLE to CBR on a granted start when any fast-page or EDO chip select is configured.
- IDLE to SD_CMD on a granted start when only SDRAM chip selects are configured.
- CBR to SD_CMD, or CBR to IDLE, after the last CBR clock, depending on whether SDRAM chip selects were captured.
- SD_CMD to SD_REC after one clock.
- SD_REC to IDLE after the recovery count.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `rfsh_busy` is 0 and every active-low strobe (`cbr_cas_n`, `cbr_ras_n`, `sd_cs_n`, `sd_ras_n`, `sd_cas_n`) is 1.
- R2: With a nonzero reload value R and no DRAM access, `rfsh_busy` first rises R+2 clocks after reset release, and later refreshes start every R+1 clocks.
- R3: For a fast-page or EDO chip select, the CBR cycle lasts L = 4 + 2·`cyc_sel` clocks (sel 0→4, 1→6, 2→8, 3→10). CAS is low at offsets 0..L/2 and RAS at offsets 1..L/2, so CAS falls one clock before RAS. `rfsh_busy` is high for all L clocks.
- R4: For an SDRAM chip select, `sd_cs_n`, `sd_ras_n` and `sd_cas_n` are low together for exactly one clock while `sd_we_n` stays 1. `rfsh_busy` then stays high for SD_REC_CLKS more clocks.
- R5: With both kinds configured, the SDRAM command comes at offset L, directly after the CBR cycle. The busy length is L+1+SD_REC_CLKS.
- R6: A refresh never starts in the clock after a DRAM chip-select access was active. A deferred request starts in the clock after that access ends.
- R7: A reload value of 0 disables refresh: no refresh starts while it is 0.
- R8: An access to a non-DRAM chip select does not delay a refresh.
- R9: After a deferred refresh, the next one starts R+1 clocks after the deferred one, not earlier.
- R10: Strobes go only to chip selects of the matching configured type. The chip-select masks and `cyc_sel` are captured at start, so changing them during a refresh does not alter that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_val | input | TMR_W | Refresh interval reload; 0 disables refresh |
| cyc_sel | input | 2 | CBR cycle-length select |
| cs_is_dram | input | NUM_CS | Chip select is DRAM |
| cs_is_sdram | input | NUM_CS | DRAM chip select is SDRAM (else fast-page/EDO) |
| acc_active | input | 1 | Normal access in progress |
| acc_cs | input | CS_W | Chip select of the current access |
| rfsh_busy | output | 1 | Refresh in progress |
| cbr_cas_n | output | NUM_CS | Per-chip-select CAS strobe for CBR |
| cbr_ras_n | output | NUM_CS | Per-chip-select RAS strobe for CBR |
| sd_cs_n | output | NUM_CS | Per-chip-select SDRAM select |
| sd_ras_n | output | 1 | SDRAM RAS command line |
| sd_cas_n | output | 1 | SDRAM CAS command line |
| sd_we_n | output | 1 | SDRAM WE command line |

## Verification
Timer expiry can fall in the same clock as a normal access, so the bench makes the interval run out in the middle of an access held for twenty clocks. With a DRAM chip select, the refresh start must move to the clock right after the access drops, and the following interval must be a full one. With a non-DRAM chip select, the start must keep its undisturbed time. A scoreboard compares each observed refresh against an expected start cycle, busy length and strobe offsets derived from the requirements.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CBR,
        ST_SD_CMD,
        ST_SD_REC
    } rf_state_e;

    // CBR cycle length in clocks for a cycle-length select value
    function automatic logic [3:0] cbr_len(input logic [1:0] sel);
        return 4'd4 + {1'b0, sel, 1'b0};
    endfunction

endpackage

// File: rtl/drfsh_timer.sv
module drfsh_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] reload_val,
    input  logic             start,
    output logic             pend
);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            pend <= 1'b0;
        end else if (reload_val == '0) begin
            tmr  <= '0;
            pend <= 1'b0;
        end else if (start) begin
            tmr  <= reload_val;
            pend <= 1'b0;
        end else if (tmr == '0) begin
            if (!pend) tmr <= reload_val;
        end else if (tmr == TMR_W'(1)) begin
            tmr  <= '0;
            pend <= 1'b1;
        end else begin
            tmr <= tmr - TMR_W'(1);
        end
    end

endmodule

// File: rtl/drfsh_seq_fsm.sv
module drfsh_seq_fsm
    import drfsh_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int SD_REC_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CS-1:0] fp_mask,
    input  logic [NUM_CS-1:0] sd_mask,
    input  logic [1:0]        cyc_sel,
    output logic              busy,
    output logic [NUM_CS-1:0] cbr_cas_n,
    output logic [NUM_CS-1:0] cbr_ras_n,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n
);

    localparam int CNT_W = (SD_REC_CLKS > 10) ? $clog2(SD_REC_CLKS + 1) : 4;

    rf_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        len_q;
    logic [NUM_CS-1:0] fp_q, sd_q;
    logic [CNT_W-1:0]  cbr_last, cbr_half;

    assign cbr_last = CNT_W'(len_q) - CNT_W'(1);
    assign cbr_half = CNT_W'(len_q >> 1);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (|fp_mask)      state_nx = ST_CBR;
                    else if (|sd_mask) state_nx = ST_SD_CMD;
                end
            end
            ST_CBR: begin
                if (cnt == cbr_last) state_nx = (|sd_q) ? ST_SD_CMD : ST_IDLE;
            end
            ST_SD_CMD: state_nx = ST_SD_REC;
            ST_SD_REC: begin
                if (cnt == CNT_W'(SD_REC_CLKS - 1)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register, phase counter and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            len_q <= 4'd4;
            fp_q  <= '0;
            sd_q  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + CNT_W'(1);
            if (state == ST_IDLE && start) begin
                len_q <= cbr_len(cyc_sel);
                fp_q  <= fp_mask;
                sd_q  <= sd_mask;
            end
        end
    end

    // strobe decode
    always_comb begin
        logic cas_on, ras_on, sd_on;
        cas_on    = (state == ST_CBR) && (cnt <= cbr_half);
        ras_on    = (state == ST_CBR) && (cnt != '0) && (cnt <= cbr_half);
        sd_on     = (state == ST_SD_CMD);
        busy      = (state != ST_IDLE);
        cbr_cas_n = ~(fp_q & {NUM_CS{cas_on}});
        cbr_ras_n = ~(fp_q & {NUM_CS{ras_on}});
        sd_cs_n   = ~(sd_q & {NUM_CS{sd_on}});
        sd_ras_n  = ~sd_on;
        sd_cas_n  = ~sd_on;
        sd_we_n   = 1'b1;
    end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int NUM_CS      = 4,
    parameter int TMR_W       = 16,
    parameter int SD_REC_CLKS = 3,
    localparam int CS_W       = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  reload_val,
    input  logic [1:0]        cyc_sel,
    input  logic [NUM_CS-1:0] cs_is_dram,
    input  logic [NUM_CS-1:0] cs_is_sdram,
    input  logic              acc_active,
    input  logic [CS_W-1:0]   acc_cs,
    output logic              rfsh_busy,
    output logic [NUM_CS-1:0] cbr_cas_n,
    output logic [NUM_CS-1:0] cbr_ras_n,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n
);

    logic [NUM_CS-1:0] fp_mask, sd_mask;
    logic              pend, start, dram_acc;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_mask
        assign fp_mask[i] = cs_is_dram[i] & ~cs_is_sdram[i];
        assign sd_mask[i] = cs_is_dram[i] &  cs_is_sdram[i];
    end

    assign dram_acc = acc_active & cs_is_dram[acc_cs];
    assign start    = pend && (reload_val != '0) && !rfsh_busy && !dram_acc;

    drfsh_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_val (reload_val),
        .start      (start),
        .pend       (pend)
    );

    drfsh_seq_fsm #(.NUM_CS(NUM_CS), .SD_REC_CLKS(SD_REC_CLKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fp_mask   (fp_mask),
        .sd_mask   (sd_mask),
        .cyc_sel   (cyc_sel),
        .busy      (rfsh_busy),
        .cbr_cas_n (cbr_cas_n),
        .cbr_ras_n (cbr_ras_n),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n)
    );

endmodule

// File: rtl/drfsh_checker.sv
module drfsh_checker #(
    parameter int NUM_CS      = 4,
    parameter int TMR_W       = 16,
    localparam int CS_W       = $clog2(NUM_CS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TMR_W-1:0]  reload_val,
    input logic [NUM_CS-1:0] cs_is_dram,
    input logic              acc_active,
    input logic [CS_W-1:0]   acc_cs,
    input logic              rfsh_busy,
    input logic [NUM_CS-1:0] cbr_cas_n,
    input logic [NUM_CS-1:0] cbr_ras_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cbr_ras_n[i]) |-> $past(!cbr_cas_n[i])); // R3
        AST_RAS_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
            !cbr_ras_n[i] |-> !cbr_cas_n[i]); // R3
    end

    AST_SD_CMD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |=> sd_ras_n); // R4
    AST_SD_CMD_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |-> (!sd_cas_n && sd_we_n)); // R4
    AST_NO_START_IN_DRAM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_busy) |-> !$past(acc_active && cs_is_dram[acc_cs])); // R6
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val == '0 && !rfsh_busy) |=> !rfsh_busy); // R7
    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cbr_cas_n) || !sd_ras_n) |-> rfsh_busy); // R10

endmodule

bind dram_refresh_seq drfsh_checker #(.NUM_CS(NUM_CS), .TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_val (reload_val),
    .cs_is_dram (cs_is_dram),
    .acc_active (acc_active),
    .acc_cs     (acc_cs),
    .rfsh_busy  (rfsh_busy),
    .cbr_cas_n  (cbr_cas_n),
    .cbr_ras_n  (cbr_ras_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

    localparam int NCS = 4;
    localparam int TW  = 16;
    localparam int REC = 3;
    localparam int RLD = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TW-1:0]  reload_val = '0;
    logic [1:0]     cyc_sel = '0;
    logic [NCS-1:0] cs_is_dram = '0, cs_is_sdram = '0;
    logic           acc_active = 1'b0;
    logic [1:0]     acc_cs = '0;
    logic           rfsh_busy, sd_ras_n, sd_cas_n, sd_we_n;
    logic [NCS-1:0] cbr_cas_n, cbr_ras_n, sd_cs_n;

    dram_refresh_seq #(.NUM_CS(NCS), .TMR_W(TW), .SD_REC_CLKS(REC)) dut (
        .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .cyc_sel(cyc_sel),
        .cs_is_dram(cs_is_dram), .cs_is_sdram(cs_is_sdram),
        .acc_active(acc_active), .acc_cs(acc_cs), .rfsh_busy(rfsh_busy),
        .cbr_cas_n(cbr_cas_n), .cbr_ras_n(cbr_ras_n), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        string    tag;
        int       start, len, cas_f, cas_l, ras_f, ras_l, sd_off, sd_cnt, we_lo;
        logic [NCS-1:0] cas_m, ras_m, sdcs_m;
    } rec_t;

    rec_t exp_q[$];
    int n_chk = 0, n_fail = 0, busy_cycles = 0, rel = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // expected item derived from the requirements
    function automatic rec_t mk(input string tag, input int start, input int sel,
                                input bit has_fp, input bit has_sd,
                                input logic [NCS-1:0] fpm, input logic [NCS-1:0] sdm);
        rec_t r;
        int L;
        L = 4 + 2 * sel;
        r.tag = tag; r.start = start; r.we_lo = 0;
        r.cas_f = -1; r.cas_l = -1; r.ras_f = -1; r.ras_l = -1;
        r.sd_off = -1; r.sd_cnt = 0; r.len = 0;
        r.cas_m = '0; r.ras_m = '0; r.sdcs_m = '0;
        if (has_fp) begin
            r.cas_f = 0; r.cas_l = L / 2; r.ras_f = 1; r.ras_l = L / 2;
            r.cas_m = fpm; r.ras_m = fpm; r.len = L;
        end
        if (has_sd) begin
            r.sd_off = r.len; r.sd_cnt = 1; r.sdcs_m = sdm;
            r.len = r.len + 1 + REC;
        end
        return r;
    endfunction

    // monitor / scoreboard
    bit   in_rf = 0;
    rec_t cur;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_rf = 0;
        end else if (rfsh_busy) begin
            busy_cycles++;
            if (!in_rf) begin
                in_rf = 1;
                cur.start = cyc; cur.len = 0; cur.we_lo = 0;
                cur.cas_f = -1; cur.cas_l = -1; cur.ras_f = -1; cur.ras_l = -1;
                cur.sd_off = -1; cur.sd_cnt = 0;
                cur.cas_m = '0; cur.ras_m = '0; cur.sdcs_m = '0;
            end
            if (~cbr_cas_n != '0) begin
                if (cur.cas_f < 0) cur.cas_f = cur.len;
                cur.cas_l = cur.len; cur.cas_m |= ~cbr_cas_n;
            end
            if (~cbr_ras_n != '0) begin
                if (cur.ras_f < 0) cur.ras_f = cur.len;
                cur.ras_l = cur.len; cur.ras_m |= ~cbr_ras_n;
            end
            if (!sd_ras_n && !sd_cas_n) begin
                if (cur.sd_off < 0) cur.sd_off = cur.len;
                cur.sd_cnt++; cur.sdcs_m |= ~sd_cs_n;
            end
            if (!sd_we_n) cur.we_lo = 1;
            cur.len++;
        end else if (in_rf) begin
            in_rf = 0;
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected refresh start", cur.start, -1);
            end else begin
                rec_t e;
                e = exp_q.pop_front();
                chk(cur.start  == e.start,  e.tag, "start cycle",   cur.start,  e.start);
                chk(cur.len    == e.len,    e.tag, "busy length",   cur.len,    e.len);
                chk(cur.cas_f  == e.cas_f,  e.tag, "CAS first",     cur.cas_f,  e.cas_f);
                chk(cur.cas_l  == e.cas_l,  e.tag, "CAS last",      cur.cas_l,  e.cas_l);
                chk(cur.ras_f  == e.ras_f,  e.tag, "RAS first",     cur.ras_f,  e.ras_f);
                chk(cur.ras_l  == e.ras_l,  e.tag, "RAS last",      cur.ras_l,  e.ras_l);
                chk(cur.sd_off == e.sd_off, e.tag, "SDRAM cmd off", cur.sd_off, e.sd_off);
                chk(cur.sd_cnt == e.sd_cnt, e.tag, "SDRAM cmd clk", cur.sd_cnt, e.sd_cnt);
                chk(cur.we_lo  == 0,        e.tag, "WE low seen",   cur.we_lo,  0);
                chk(cur.cas_m  == e.cas_m,  e.tag, "CAS cs mask",   int'(cur.cas_m),  int'(e.cas_m));
                chk(cur.ras_m  == e.ras_m,  e.tag, "RAS cs mask",   int'(cur.ras_m),  int'(e.ras_m));
                chk(cur.sdcs_m == e.sdcs_m, e.tag, "SD cs mask",    int'(cur.sdcs_m), int'(e.sdcs_m));
            end
        end
    end

    task automatic wait_cyc(input int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic begin_scn(input int sel, input logic [NCS-1:0] dr,
                             input logic [NCS-1:0] sd, input int rld, input bit chk_rst);
        @(negedge clk);
        rst_n = 1'b0; acc_active = 1'b0; acc_cs = '0;
        cyc_sel = 2'(sel); cs_is_dram = dr; cs_is_sdram = sd; reload_val = TW'(rld);
        repeat (3) @(negedge clk);
        if (chk_rst) begin
            chk(rfsh_busy == 1'b0,  "R1", "busy in reset",  int'(rfsh_busy), 0);
            chk(&cbr_cas_n,         "R1", "CAS in reset",   int'(cbr_cas_n), 15);
            chk(&cbr_ras_n,         "R1", "RAS in reset",   int'(cbr_ras_n), 15);
            chk(&sd_cs_n && sd_ras_n && sd_cas_n, "R1", "SD lines in reset", int'(sd_cs_n), 15);
        end
        rst_n = 1'b1;
        rel = cyc;
        busy_cycles = 0;
    endtask

    task automatic end_scn(input string tag, input int last_start);
        wait_cyc(last_start + 15);
        reload_val = '0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, tag, "expected refreshes left", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        // R2 / R3 / R10: fast-page chip select 0 only, shortest cycle, two intervals
        begin_scn(0, 4'b0001, 4'b0000, RLD, 1);
        exp_q.push_back(mk("R2", rel + RLD + 2, 0, 1, 0, 4'b0001, 4'b0000));
        exp_q.push_back(mk("R2", rel + 2 * RLD + 3, 0, 1, 0, 4'b0001, 4'b0000));
        end_scn("R2", rel + 2 * RLD + 3);

        // R3 / R10: longest cycle on chip selects 1 and 2; select changed mid-refresh
        begin_scn(3, 4'b0110, 4'b0000, RLD, 0);
        exp_q.push_back(mk("R10", rel + RLD + 2, 3, 1, 0, 4'b0110, 4'b0000));
        wait_cyc(rel + RLD + 3);
        cyc_sel = 2'd0;
        cs_is_dram = 4'b1111;
        end_scn("R10", rel + RLD + 2);

        // R3: middle cycle lengths
        for (int s = 1; s <= 2; s++) begin
            begin_scn(s, 4'b0001, 4'b0000, RLD, 0);
            exp_q.push_back(mk("R3", rel + RLD + 2, s, 1, 0, 4'b0001, 4'b0000));
            end_scn("R3", rel + RLD + 2);
        end

        // R4: SDRAM only on chip select 3
        begin_scn(0, 4'b1000, 4'b1000, RLD, 0);
        exp_q.push_back(mk("R4", rel + RLD + 2, 0, 0, 1, 4'b0000, 4'b1000));
        end_scn("R4", rel + RLD + 2);

        // R5: mixed, CBR then SDRAM command
        begin_scn(0, 4'b1001, 4'b1000, RLD, 0);
        exp_q.push_back(mk("R5", rel + RLD + 2, 0, 1, 1, 4'b0001, 4'b1000));
        end_scn("R5", rel + RLD + 2);

        // R6 / R9: expiry during a DRAM access defers start; next interval is full
        begin_scn(0, 4'b0001, 4'b0000, RLD, 0);
        exp_q.push_back(mk("R6", rel + 31, 0, 1, 0, 4'b0001, 4'b0000));
        exp_q.push_back(mk("R9", rel + 31 + RLD + 1, 0, 1, 0, 4'b0001, 4'b0000));
        wait_cyc(rel + 10);
        acc_active = 1'b1; acc_cs = 2'd0;
        wait_cyc(rel + 30);
        acc_active = 1'b0;
        end_scn("R9", rel + 31 + RLD + 1);

        // R8: access to non-DRAM chip select 2 does not delay refresh
        begin_scn(0, 4'b0001, 4'b0000, RLD, 0);
        exp_q.push_back(mk("R8", rel + RLD + 2, 0, 1, 0, 4'b0001, 4'b0000));
        wait_cyc(rel + 10);
        acc_active = 1'b1; acc_cs = 2'd2;
        wait_cyc(rel + 30);
        acc_active = 1'b0;
        end_scn("R8", rel + RLD + 2);

        // R7: zero reload value, no refresh at all
        begin_scn(0, 4'b1001, 4'b1000, 0, 0);
        repeat (100) @(negedge clk);
        chk(busy_cycles == 0, "R7", "busy clocks with reload 0", busy_cycles, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule